// File: doc/BRIEF.md
# Multi-Mode DAC Waveform Player

The waveform player feeds a remote digital-to-analog converter with one 16-bit link word per system-clock cycle. At a 125 MHz clock this gives up to 125 Msps. Each word carries a 14-bit converter code in bits 15:2, and bits 1:0 are always zero. Samples come in over an AXI4-Stream input. In the buffered modes they are stored in a local sample memory. In streaming mode they pass straight through to the output.

Three playback modes are available:

- **Single pulse:** a start strobe plays the stored waveform once.
- **Periodic:** the stored waveform repeats with a programmable repetition period counted in clock cycles. For example, 2500 cycles gives a 20 µs period.
- **Streaming:** each incoming beat goes to the output on the next cycle. A sticky underflow flag records every cycle in which no beat was available.

Whenever nothing is being played, the output carries a programmable idle code. A requested mode change is accepted only while playback is stopped, or at the end of a repetition period.

Top module: `wave_player`

## Requirements
- R1: The output word `dac_word` always carries the 14-bit code in bits 15:2, with bits 1:0 driven to zero.
- R2: While `rst_n` is low and at the first sample after it, `dac_word` is 0, `busy` is 0, `underflow` is 0 and `cur_mode` is 0.
- R3: In any mode other than streaming, each input beat (`s_tready` is always 1) is stored at the next buffer slot, starting at slot 0. A beat with `s_tlast` set makes the following beat go to slot 0 again.
- R4: Mode code 1 is single pulse. A `play_start` sampled on edge k plays slots 0..L-1 once, where L is the clamped `cfg_len`. Slot i appears on `dac_word` after edge k+1+i, and the idle code follows.
- R5: Mode code 2 is periodic. After `play_start` on edge k, the output after edge k+1+j is slot (j mod P) when (j mod P) < L, and the idle code otherwise. P is the repetition period in cycles.
- R6: A `cfg_period` smaller than the waveform length is treated as equal to the length, so the waveform repeats back to back.
- R7: Mode code 3 is streaming. A beat accepted on an edge appears on `dac_word` after that same edge. Beats received in streaming mode are not written to the buffer.
- R8: In streaming mode, a cycle with no valid beat outputs the idle code and sets `underflow`. `underflow` stays set until a `uf_clear` arrives in a cycle that is not itself underflowing; in a cycle that is both, the set wins.
- R9: A change of `cfg_mode` while `busy` is high leaves `cur_mode` unchanged. At the end of the current period the new mode is taken and playback stops if it is not periodic.
- R10: When mode code 0 is selected, or when no waveform slot is playing in a buffered mode, `dac_word` carries `cfg_idle` in bits 15:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 14 | Stream sample code |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a waveform load |
| s_tready | output | 1 | Always ready |
| cfg_mode | input | 2 | Requested mode: 0 off, 1 pulse, 2 periodic, 3 streaming |
| cfg_len | input | 7 | Waveform length in samples (0 treated as 1, capped at DEPTH) |
| cfg_period | input | 16 | Repetition period in clock cycles |
| cfg_idle | input | 14 | Idle code |
| play_start | input | 1 | Start strobe for pulse and periodic modes |
| uf_clear | input | 1 | Clears the underflow flag |
| dac_word | output | 16 | Link word to the converter |
| busy | output | 1 | Pulse or periodic playback in progress |
| underflow | output | 1 | Sticky streaming underflow flag |
| cur_mode | output | 2 | Mode currently in force |

## Verification
Two pairs of functions can collide in a single cycle.

The first pair is setting and clearing the underflow flag. The bench holds `uf_clear` high during a cycle with no valid beat and expects the flag to stay set. It then holds `uf_clear` high during a cycle with a valid beat and expects the flag to clear.

The second pair is a mode change and the end of a repetition period. The bench drops the mode request in the middle of a period. It expects `cur_mode` and `busy` to hold until the final slot of the period, and the idle code to appear from exactly the next cycle.

// File: rtl/wplay_pkg.sv
// Shared definitions for the waveform player.
// Assumes a two-bit mode field decoded identically by all submodules.
package wplay_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_PULSE  = 2'd1,
        MODE_PERIOD = 2'd2,
        MODE_STREAM = 2'd3
    } play_mode_e;
endpackage

// File: rtl/wplay_buffer.sv
// Sample memory with an auto-incrementing write pointer and combinational read.
// Assumes the caller gates writes off in streaming mode; tlast rewinds the pointer.
module wplay_buffer #(
    parameter int DEPTH = 64,
    parameter int CW    = 14,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          wr_last,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    logic [CW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;

    // Advance the write slot; rewind at tlast or at the top of the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (wr_en) begin
            if (wr_last || wptr == AW'(DEPTH - 1)) begin
                wptr <= '0;
            end else begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    // Store the accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    // Present the currently addressed slot.
    always_comb begin
        rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/wplay_seq.sv
// Playback sequencer: holds the mode in force, the run flag and the cycle counter.
// Assumes PW is wide enough for DEPTH. Mode requests apply only when stopped or at period end.
module wplay_seq
    import wplay_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  play_mode_e    cfg_mode,
    input  logic [LW-1:0] cfg_len,
    input  logic [PW-1:0] cfg_period,
    input  logic          play_start,
    output play_mode_e    mode,
    output logic          run,
    output logic          in_wave,
    output logic [AW-1:0] rd_addr
);
    logic [LW-1:0] len_clip;
    logic [PW-1:0] len_eff;
    logic [PW-1:0] per_eff;
    logic [PW-1:0] len_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] pcnt;

    // Clamp the requested length to 1..DEPTH.
    always_comb begin
        if (cfg_len == '0) begin
            len_clip = LW'(1);
        end else if (cfg_len > LW'(DEPTH)) begin
            len_clip = LW'(DEPTH);
        end else begin
            len_clip = cfg_len;
        end
        len_eff = PW'(len_clip);
    end

    // Raise a period shorter than the waveform to the waveform length.
    always_comb begin
        per_eff = (cfg_period < len_eff) ? len_eff : cfg_period;
    end

    // Sequence the start, the stepping, the period wrap and the mode handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_OFF;
            run   <= 1'b0;
            pcnt  <= '0;
            len_q <= PW'(1);
            per_q <= PW'(1);
        end else if (!run) begin
            mode <= cfg_mode;
            if (play_start && (mode == MODE_PULSE || mode == MODE_PERIOD)) begin
                run   <= 1'b1;
                pcnt  <= '0;
                len_q <= len_eff;
                per_q <= per_eff;
            end
        end else if (mode == MODE_PULSE) begin
            if (pcnt == len_q - PW'(1)) begin
                run <= 1'b0;
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end else begin
            if (pcnt == per_q - PW'(1)) begin
                pcnt  <= '0;
                mode  <= cfg_mode;
                len_q <= len_eff;
                per_q <= per_eff;
                if (cfg_mode != MODE_PERIOD) begin
                    run <= 1'b0;
                end
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end

    // Flag cycles that emit a waveform slot, and address that slot.
    always_comb begin
        in_wave = run && (pcnt < len_q);
        rd_addr = pcnt[AW-1:0];
    end
endmodule

// File: rtl/wplay_out.sv
// Output stage: picks stream, buffer or idle code, packs the link word, and keeps the underflow flag.
// Assumes the stream input is always accepted in streaming mode.
module wplay_out
    import wplay_pkg::*;
#(
    parameter int CW  = 14,
    localparam int WW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  play_mode_e    mode,
    input  logic          in_wave,
    input  logic [CW-1:0] buf_data,
    input  logic [CW-1:0] strm_data,
    input  logic          strm_valid,
    input  logic [CW-1:0] idle_code,
    input  logic          uf_clear,
    output logic [WW-1:0] dac_word,
    output logic          underflow
);
    logic [CW-1:0] code_sel;
    logic          starve;

    // Choose the code for the next link word.
    always_comb begin
        starve = (mode == MODE_STREAM) && !strm_valid;
        if (mode == MODE_STREAM) begin
            code_sel = strm_valid ? strm_data : idle_code;
        end else if (in_wave) begin
            code_sel = buf_data;
        end else begin
            code_sel = idle_code;
        end
    end

    // Register the packed word with the low bits zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word <= '0;
        end else begin
            dac_word <= {code_sel, 2'b00};
        end
    end

    // Keep the sticky underflow flag; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (starve) begin
            underflow <= 1'b1;
        end else if (uf_clear) begin
            underflow <= 1'b0;
        end
    end
endmodule

// File: rtl/wave_player.sv
// Top of the waveform player: buffer, sequencer and output stage.
// Assumes a single clock domain; the stream input never back-pressures.
module wave_player
    import wplay_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 14,
    parameter int PW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW-1:0]              s_tdata,
    input  logic                       s_tvalid,
    input  logic                       s_tlast,
    output logic                       s_tready,
    input  logic [1:0]                 cfg_mode,
    input  logic [$clog2(DEPTH+1)-1:0] cfg_len,
    input  logic [PW-1:0]              cfg_period,
    input  logic [CW-1:0]              cfg_idle,
    input  logic                       play_start,
    input  logic                       uf_clear,
    output logic [CW+1:0]              dac_word,
    output logic                       busy,
    output logic                       underflow,
    output logic [1:0]                 cur_mode
);
    localparam int AW = $clog2(DEPTH);

    play_mode_e    mode;
    logic          run;
    logic          in_wave;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] rd_data;
    logic          wr_en;

    // Steer beats into the buffer except while streaming.
    always_comb begin
        s_tready = 1'b1;
        wr_en    = s_tvalid && (mode != MODE_STREAM);
        busy     = run;
        cur_mode = mode;
    end

    wplay_buffer #(.DEPTH(DEPTH), .CW(CW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (s_tdata),
        .wr_last (s_tlast),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wplay_seq #(.DEPTH(DEPTH), .PW(PW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (play_mode_e'(cfg_mode)),
        .cfg_len    (cfg_len),
        .cfg_period (cfg_period),
        .play_start (play_start),
        .mode       (mode),
        .run        (run),
        .in_wave    (in_wave),
        .rd_addr    (rd_addr)
    );

    wplay_out #(.CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .in_wave    (in_wave),
        .buf_data   (rd_data),
        .strm_data  (s_tdata),
        .strm_valid (s_tvalid),
        .idle_code  (cfg_idle),
        .uf_clear   (uf_clear),
        .dac_word   (dac_word),
        .underflow  (underflow)
    );
endmodule

// File: rtl/wplay_checker.sv
// Temporal checks on the waveform player ports, bound to every instance.
// Assumes the mode codes 0 off, 1 pulse, 2 periodic, 3 streaming.
module wplay_checker #(
    parameter int CW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] s_tdata,
    input logic          s_tvalid,
    input logic [CW-1:0] cfg_idle,
    input logic          uf_clear,
    input logic [CW+1:0] dac_word,
    input logic          busy,
    input logic          underflow,
    input logic [1:0]    cur_mode
);
    // R7: a streamed beat reaches the link one edge later.
    p_stream_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd3 && s_tvalid) |=> (dac_word == {$past(s_tdata), 2'b00}));

    // R8: a starved streaming cycle raises the flag.
    p_uf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd3 && !s_tvalid) |=> underflow);

    // R8: the flag holds without a clear.
    p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !uf_clear) |=> underflow);

    // R9: the mode in force is stable across busy cycles.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_mode));

    // R10: the idle code follows any stopped buffered-mode cycle.
    p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(busy) && $past(cur_mode) != 2'd3)
        |-> (dac_word == {$past(cfg_idle), 2'b00}));
endmodule

bind wave_player wplay_checker #(.CW(CW)) i_wplay_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tdata   (s_tdata),
    .s_tvalid  (s_tvalid),
    .cfg_idle  (cfg_idle),
    .uf_clear  (uf_clear),
    .dac_word  (dac_word),
    .busy      (busy),
    .underflow (underflow),
    .cur_mode  (cur_mode)
);

// File: tb/test_wave_player.sv
`timescale 1ns/1ps
// Directed bench for the waveform player: one task per scenario, each checking its own results.
module test_wave_player;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tlast = 1'b0;
    logic          s_tready;
    logic [1:0]    cfg_mode = 2'd0;
    logic [6:0]    cfg_len = 7'd4;
    logic [15:0]   cfg_period = 16'd10;
    logic [CW-1:0] cfg_idle = 14'h00AA;
    logic          play_start = 1'b0;
    logic          uf_clear = 1'b0;
    logic [15:0]   dac_word;
    logic          busy;
    logic          underflow;
    logic [1:0]    cur_mode;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    logic [CW-1:0] mdl [64];
    int mptr = 0;

    always #4 clk = ~clk;

    wave_player i_wave_player (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .cfg_mode(cfg_mode),
        .cfg_len(cfg_len), .cfg_period(cfg_period), .cfg_idle(cfg_idle),
        .play_start(play_start), .uf_clear(uf_clear), .dac_word(dac_word),
        .busy(busy), .underflow(underflow), .cur_mode(cur_mode)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word(logic [CW-1:0] c);
        return {c, 2'b00};
    endfunction

    // R3: one beat into the buffer, mirrored in the bench model.
    task automatic send(logic [CW-1:0] c, bit last);
        @(negedge clk);
        s_tdata = c; s_tvalid = 1'b1; s_tlast = last;
        mdl[mptr] = c;
        mptr = last ? 0 : mptr + 1;
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R2 dac_word", dac_word, 0);
        check("R2 busy", busy, 0);
        check("R2 underflow", underflow, 0);
        check("R2 cur_mode", cur_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 s_tready", s_tready, 1);
    endtask

    task automatic t_off_idle();
        for (int i = 0; i < 8; i++) send(14'h0100 + 14'(i * 37), i == 7);
        @(negedge clk);
        check("R10 idle while off", dac_word, word(cfg_idle));
        check("R1 low bits", dac_word[1:0], 0);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        @(negedge clk);
    endtask

    task automatic play_pulse(int len, string tag);
        cfg_len = 7'(len);
        @(negedge clk); play_start = 1'b1;
        @(negedge clk); play_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check(tag, dac_word, word(mdl[i]));
        end
        @(negedge clk);
        check({tag, " idle after"}, dac_word, word(cfg_idle));
        check({tag, " busy low"}, busy, 0);
    endtask

    task automatic t_pulse();
        set_mode(2'd1);
        play_pulse(4, "R4 pulse");
        send(14'h3F01, 1'b0);
        send(14'h2A02, 1'b1);
        play_pulse(4, "R3 reload");
        check("R1 low bits", dac_word[1:0], 0);
    endtask

    // R5 periodic with a mid-period drop of the request (R9).
    task automatic t_periodic();
        logic [15:0] e;
        set_mode(2'd2);
        cfg_len = 7'd4; cfg_period = 16'd10;
        @(negedge clk); play_start = 1'b1;
        @(negedge clk); play_start = 1'b0;
        for (int j = 0; j < 26; j++) begin
            @(negedge clk);
            e = (j < 20 && (j % 10) < 4) ? word(mdl[j % 10]) : word(cfg_idle);
            check(j < 20 ? "R5 periodic" : "R9 stop at period end", dac_word, e);
            if (j == 12) cfg_mode = 2'd0;
            if (j == 15) begin
                check("R9 mode held", cur_mode, 2);
                check("R9 busy held", busy, 1);
            end
        end
        check("R9 mode taken", cur_mode, 0);
    endtask

    task automatic t_clamp();
        logic [15:0] e;
        set_mode(2'd2);
        cfg_len = 7'd4; cfg_period = 16'd2;
        @(negedge clk); play_start = 1'b1;
        @(negedge clk); play_start = 1'b0;
        for (int j = 0; j < 14; j++) begin
            @(negedge clk);
            e = (j < 12) ? word(mdl[j % 4]) : word(cfg_idle);
            check("R6 clamped period", dac_word, e);
            if (j == 7) cfg_mode = 2'd0;
        end
    endtask

    task automatic t_stream();
        @(negedge clk); cfg_mode = 2'd3;
        @(negedge clk);
        check("R7 mode stream", cur_mode, 3);
        check("R8 no underflow yet", underflow, 0);
        for (int i = 0; i < 5; i++) begin
            s_tvalid = 1'b1; s_tdata = 14'h1234 + 14'(i * 101);
            @(negedge clk);
            check("R7 stream pass", dac_word, word(14'h1234 + 14'(i * 101)));
            check("R8 no underflow", underflow, 0);
        end
        s_tvalid = 1'b0;
        @(negedge clk);
        check("R8 idle on starve", dac_word, word(cfg_idle));
        check("R8 flag set", underflow, 1);
        s_tvalid = 1'b1; s_tdata = 14'h0777;
        @(negedge clk);
        check("R8 sticky", underflow, 1);
        s_tvalid = 1'b0; uf_clear = 1'b1;
        @(negedge clk);
        check("R8 set wins over clear", underflow, 1);
        s_tvalid = 1'b1; s_tdata = 14'h0555;
        @(negedge clk);
        check("R8 cleared", underflow, 0);
        uf_clear = 1'b0;
        cfg_mode = 2'd1; s_tvalid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        play_pulse(4, "R7 buffer untouched by stream");
    endtask

    initial begin
        t_reset();
        t_off_idle();
        t_pulse();
        t_periodic();
        t_clamp();
        t_stream();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule